// File: doc/BRIEF.md
# Device Configuration Sequencer

This block steps a programmable logic device through its configuration flow. It starts when both supply-good flags are up after reset, or when a falling edge arrives on the active-low program line while the device is in user operation or stuck after a failed load. It holds the shared active-low init line down and keeps done low while a cycle-counted memory clear runs. It stays in the clear for as long as program is still held low. It then waits until no outside party holds init low.

Next it latches the three mode pins once and hands them to an external frame loader, together with a one-cycle start pulse. It waits for the loader's completion strobe and reads the CRC flag that comes with it. A bad CRC parks the block in an error state with init pulled low. A good CRC runs a three-cycle start-up: done first, then the user I/O enable, then release of global set/reset.

All asynchronous inputs pass through two-flop synchronizers. The init line is sensed as the wire level, which includes the block's own pull-down.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset, init_low is 1 and done_out, io_enable, gsr_release and ldr_start are 0. This state holds until both vcco_ok and vccint_ok are 1.
- R2: Once both supplies read 1, init_low stays 1 for exactly CLEAR_CYCLES+2 cycles: two cycles of synchronization and CLEAR_CYCLES cycles of clearing. It then drops to 0.
- R3: If prog_n is still 0 when the clear count ends, init_low stays 1. It drops on the third clock edge after prog_n returns to 1.
- R4: After clearing, no ldr_start occurs while init_n_sense is held 0 from outside. After the line is released, ldr_start is 1 in the fourth cycle.
- R5: mode_pins are latched in the cycle before ldr_start. ldr_mode shows that value and ignores later pin changes until the next configuration.
- R6: ldr_start is 1 for a single cycle. While the block waits for ldr_complete, done_out is 0 and init_low is 0.
- R7: ldr_complete with ldr_crc_ok=0 sets init_low to 1 and keeps done_out, io_enable and gsr_release at 0 on the next cycle. This lasts until a program request.
- R8: ldr_complete with ldr_crc_ok=1 raises done_out on the next cycle, io_enable one cycle later and gsr_release one cycle after that. All three then stay 1.
- R9: In user operation, a falling edge on prog_n sets init_low to 1 and clears done_out on the third edge. A single low pulse causes exactly one new clear and exactly one ldr_start.
- R10: In the error state, a falling edge on prog_n restarts the clear with the same three-edge latency as R9.
- R11: ldr_complete has no effect outside the frame-loading wait. In user operation, all outputs are unchanged after a completion strobe with either CRC value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vcco_ok | input | 1 | I/O bank supply good |
| vccint_ok | input | 1 | Core supply good |
| prog_n | input | 1 | Active-low program request (asynchronous) |
| init_n_sense | input | 1 | Sensed level of the shared open-drain init line |
| mode_pins | input | MODE_W | Configuration mode select |
| ldr_complete | input | 1 | Frame loader finished strobe |
| ldr_crc_ok | input | 1 | CRC result, valid with ldr_complete |
| init_low | output | 1 | Pull the init line low |
| done_out | output | 1 | Done indication |
| io_enable | output | 1 | User I/O enable |
| gsr_release | output | 1 | Global set/reset released |
| ldr_start | output | 1 | One-cycle start pulse to the frame loader |
| ldr_mode | output | MODE_W | Latched mode for the frame loader |

## Verification
Every one of the eight mode values is run through a full reconfiguration, with the mode pins changed right after the start pulse. This separates latching from pass-through. The CRC result alternates across the sweep, so restarts are tried from both user operation and the error state, and the two restart paths are shown to share one latency. Two patterns are held long instead of pulsed: an external hold on init and a held program line. Each is timed to the exact cycle of release, which separates a level wait from a timeout. A completion strobe sent during user operation shows that the handshake is ignored outside loading.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [3:0] {
    ST_POR,
    ST_CLEAR,
    ST_WAIT_INIT,
    ST_SAMPLE,
    ST_START,
    ST_LOAD,
    ST_SU_DONE,
    ST_SU_IO,
    ST_SU_GSR,
    ST_USER,
    ST_ERROR
  } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
  parameter int CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign expired = (cnt_q == CW'(CYCLES - 1));
  assign cnt_en  = restart | (run & ~expired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= restart ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supplies_ok,
  input  logic              prog_s,
  input  logic              init_s,
  input  logic              clr_expired,
  input  logic              ldr_complete,
  input  logic              ldr_crc_ok,
  input  logic [MODE_W-1:0] mode_pins,
  output logic              clr_restart,
  output logic              clr_run,
  output logic              init_low,
  output logic              done_out,
  output logic              io_enable,
  output logic              gsr_release,
  output logic              ldr_start,
  output logic [MODE_W-1:0] ldr_mode
);
  cfg_state_e        state_q, state_d;
  logic              prog_prev_q;
  logic              prog_fall;
  logic [MODE_W-1:0] mode_q;
  logic              mode_en;

  assign prog_fall = prog_prev_q & ~prog_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_POR:       if (supplies_ok)            state_d = ST_CLEAR;
      ST_CLEAR:     if (clr_expired && prog_s)  state_d = ST_WAIT_INIT;
      ST_WAIT_INIT: if (init_s)                 state_d = ST_SAMPLE;
      ST_SAMPLE:                                state_d = ST_START;
      ST_START:                                 state_d = ST_LOAD;
      ST_LOAD:      if (ldr_complete)           state_d = ldr_crc_ok ? ST_SU_DONE : ST_ERROR;
      ST_SU_DONE:                               state_d = ST_SU_IO;
      ST_SU_IO:                                 state_d = ST_SU_GSR;
      ST_SU_GSR:                                state_d = ST_USER;
      ST_USER:      if (prog_fall)              state_d = ST_CLEAR;
      ST_ERROR:     if (prog_fall)              state_d = ST_CLEAR;
      default:                                  state_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_POR;
      prog_prev_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      prog_prev_q <= prog_s;
    end
  end

  assign mode_en = (state_q == ST_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_pins;
    end
  end

  assign clr_restart = (state_d == ST_CLEAR) && (state_q != ST_CLEAR);
  assign clr_run     = (state_q == ST_CLEAR);
  assign init_low    = (state_q == ST_POR) || (state_q == ST_CLEAR) || (state_q == ST_ERROR);
  assign done_out    = (state_q == ST_SU_DONE) || (state_q == ST_SU_IO) ||
                       (state_q == ST_SU_GSR)  || (state_q == ST_USER);
  assign io_enable   = (state_q == ST_SU_IO) || (state_q == ST_SU_GSR) || (state_q == ST_USER);
  assign gsr_release = (state_q == ST_SU_GSR) || (state_q == ST_USER);
  assign ldr_start   = (state_q == ST_START);
  assign ldr_mode    = mode_q;
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
  parameter int CLEAR_CYCLES = 256,
  parameter int MODE_W       = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcco_ok,
  input  logic              vccint_ok,
  input  logic              prog_n,
  input  logic              init_n_sense,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              ldr_complete,
  input  logic              ldr_crc_ok,
  output logic              init_low,
  output logic              done_out,
  output logic              io_enable,
  output logic              gsr_release,
  output logic              ldr_start,
  output logic [MODE_W-1:0] ldr_mode
);
  localparam int           N_ASYNC  = 4;
  localparam logic [N_ASYNC-1:0] ASYNC_RST = 4'b0011;

  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [N_ASYNC-1:0] async_raw;
  logic [N_ASYNC-1:0] async_s;
  logic               clr_restart;
  logic               clr_run;
  logic               clr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign async_raw = {vccint_ok, vcco_ok, init_n_sense, prog_n};

  cfg_sync #(
    .W       (N_ASYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (ASYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (async_raw),
    .q     (async_s)
  );

  cfg_clear_timer #(
    .CYCLES (CLEAR_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (clr_restart),
    .run     (clr_run),
    .expired (clr_expired)
  );

  cfg_seq_fsm #(
    .MODE_W (MODE_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .supplies_ok  (async_s[3] & async_s[2]),
    .prog_s       (async_s[0]),
    .init_s       (async_s[1]),
    .clr_expired  (clr_expired),
    .ldr_complete (ldr_complete),
    .ldr_crc_ok   (ldr_crc_ok),
    .mode_pins    (mode_pins),
    .clr_restart  (clr_restart),
    .clr_run      (clr_run),
    .init_low     (init_low),
    .done_out     (done_out),
    .io_enable    (io_enable),
    .gsr_release  (gsr_release),
    .ldr_start    (ldr_start),
    .ldr_mode     (ldr_mode)
  );
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_low,
  input logic              done_out,
  input logic              io_enable,
  input logic              gsr_release,
  input logic              ldr_start,
  input logic [MODE_W-1:0] ldr_mode
);
  AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    io_enable |-> done_out) else $error("io_enable without done"); // R8
  AST_GSR_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    gsr_release |-> io_enable) else $error("gsr released before io"); // R8
  AST_DONE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_out) |-> !io_enable && !gsr_release) else $error("done not first"); // R8
  AST_DONE_INIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |-> !init_low) else $error("done with init low"); // R7
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_start |=> !ldr_start) else $error("start longer than one cycle"); // R6
  AST_START_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_start |-> !done_out && !init_low) else $error("start during done/init"); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ldr_start |-> $stable(ldr_mode)) else $error("mode changed outside start"); // R5
endmodule

bind cfg_seq_top cfg_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_low    (init_low),
  .done_out    (done_out),
  .io_enable   (io_enable),
  .gsr_release (gsr_release),
  .ldr_start   (ldr_start),
  .ldr_mode    (ldr_mode)
);

// File: tb/cfg_seq_top_tb.sv
module cfg_seq_top_tb;
  localparam int N  = 12;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vcco_ok, vccint_ok, prog_n, ext_init_n;
  logic [MW-1:0] mode_pins;
  logic          ldr_complete, ldr_crc_ok;
  logic          init_low, done_out, io_enable, gsr_release, ldr_start;
  logic [MW-1:0] ldr_mode;
  logic          init_wire;

  int n_vec = 0;
  int n_bad = 0;

  always #10ns clk = ~clk;

  assign init_wire = ~init_low & ext_init_n;

  cfg_seq_top #(.CLEAR_CYCLES(N), .MODE_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vcco_ok(vcco_ok), .vccint_ok(vccint_ok),
    .prog_n(prog_n), .init_n_sense(init_wire), .mode_pins(mode_pins),
    .ldr_complete(ldr_complete), .ldr_crc_ok(ldr_crc_ok),
    .init_low(init_low), .done_out(done_out), .io_enable(io_enable),
    .gsr_release(gsr_release), .ldr_start(ldr_start), .ldr_mode(ldr_mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_start(output int lat);
    lat = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      lat++;
      if (ldr_start) break;
    end
  endtask

  task automatic pulse_complete(input logic crc);
    ldr_complete = 1'b1;
    ldr_crc_ok   = crc;
    @(negedge clk);
    ldr_complete = 1'b0;
    ldr_crc_ok   = 1'b0;
  endtask

  task automatic check_startup();
    chk("R8", "done step1", int'(done_out), 1);
    chk("R8", "io step1", int'(io_enable), 0);
    chk("R8", "gsr step1", int'(gsr_release), 0);
    @(negedge clk);
    chk("R8", "io step2", int'(io_enable), 1);
    chk("R8", "gsr step2", int'(gsr_release), 0);
    @(negedge clk);
    chk("R8", "gsr step3", int'(gsr_release), 1);
    chk("R8", "done held", int'(done_out), 1);
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL all: watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int    cnt, lat, starts;
    bit    good, from_err;
    string rq;

    rst_n = 1'b0; vcco_ok = 1'b0; vccint_ok = 1'b0; prog_n = 1'b1;
    ext_init_n = 1'b1; mode_pins = '0; ldr_complete = 1'b0; ldr_crc_ok = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1", "init_low", int'(init_low), 1);
    chk("R1", "done", int'(done_out), 0);
    chk("R1", "io", int'(io_enable), 0);
    chk("R1", "gsr", int'(gsr_release), 0);
    chk("R1", "start", int'(ldr_start), 0);

    // R1: one supply is not enough
    vcco_ok = 1'b1;
    starts = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ldr_start || !init_low) starts++;
    end
    chk("R1", "single supply activity", starts, 0);

    // R2 / R4: clear length, external init hold
    ext_init_n = 1'b0;
    mode_pins  = 3'd5;
    vccint_ok  = 1'b1;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (init_low) cnt++;
      else break;
    end
    chk("R2", "init low cycles", cnt, N + 2);
    starts = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ldr_start) starts++;
    end
    chk("R4", "start while init held", starts, 0);
    ext_init_n = 1'b1;
    wait_start(lat);
    chk("R4", "start latency", lat, 4);
    chk("R5", "mode at start", int'(ldr_mode), 5);
    mode_pins = 3'd2;
    @(negedge clk);
    chk("R6", "start pulse width", int'(ldr_start), 0);
    chk("R5", "mode after pin change", int'(ldr_mode), 5);
    repeat (8) @(negedge clk);
    chk("R6", "done during load", int'(done_out), 0);
    chk("R6", "init during load", int'(init_low), 0);
    pulse_complete(1'b1);
    check_startup();

    // R11: stray completion in user operation
    repeat (3) @(negedge clk);
    pulse_complete(1'b0);
    repeat (4) @(negedge clk);
    chk("R11", "done kept", int'(done_out), 1);
    chk("R11", "gsr kept", int'(gsr_release), 1);
    chk("R11", "init not driven", int'(init_low), 0);
    pulse_complete(1'b1);
    chk("R11", "start not issued", int'(ldr_start), 0);
    chk("R11", "io kept", int'(io_enable), 1);

    // Sweep all modes, alternating CRC result; restart from user and error
    for (int m = 0; m < 8; m++) begin
      good      = (m % 3) != 0;
      from_err  = !done_out;
      rq        = from_err ? "R10" : "R9";
      mode_pins = MW'(m);
      prog_n    = 1'b0;
      repeat (2) @(negedge clk);
      chk(rq, "old state kept 2nd edge", int'(done_out), from_err ? 0 : 1);
      @(negedge clk);
      chk(rq, "init low 3rd edge", int'(init_low), 1);
      chk(rq, "done cleared 3rd edge", int'(done_out), 0);
      prog_n = 1'b1;
      wait_start(lat);
      chk(rq, "restart to start", lat + 3, N + 7);
      chk("R5", "mode latched", int'(ldr_mode), m);
      mode_pins = ~MW'(m);
      @(negedge clk);
      chk("R6", "start one cycle", int'(ldr_start), 0);
      chk("R5", "mode held", int'(ldr_mode), m);
      repeat (4) @(negedge clk);
      pulse_complete(good);
      if (good) begin
        check_startup();
        starts = 0;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          if (ldr_start) starts++;
        end
        chk("R9", "single reconfiguration", starts, 0);
        chk("R9", "user held", int'(done_out), 1);
      end else begin
        chk("R7", "init low on bad crc", int'(init_low), 1);
        chk("R7", "done low on bad crc", int'(done_out), 0);
        repeat (20) @(negedge clk);
        chk("R7", "error init held", int'(init_low), 1);
        chk("R7", "error done held", int'(done_out), 0);
        chk("R7", "error io off", int'(io_enable), 0);
      end
    end

    // R3: program held low past the clear count (ends in user after m=7)
    prog_n = 1'b0;
    repeat (N + 20) @(negedge clk);
    chk("R3", "clear held by program", int'(init_low), 1);
    prog_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3", "still clearing 2nd edge", int'(init_low), 1);
    @(negedge clk);
    chk("R3", "released 3rd edge", int'(init_low), 0);
    wait_start(lat);
    chk("R3", "load after held program", int'(ldr_start), 1);
    @(negedge clk);
    pulse_complete(1'b1);
    check_startup();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule